// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block connects a single-beat valid/ready request port to an asynchronous 128K x 8 static memory. Each accepted request becomes one access. The address and write data are latched, and the block then drives the memory's two chip selects, its output enable and its write strobe. Each strobe is held for a whole number of clock cycles. The block computes these counts at elaboration time by rounding up each nanosecond limit of the memory against the clock period.

A read returns its byte as a one-cycle response pulse. After a read, the block waits while the memory's outputs float before it accepts the next request. A write drives the data bus only while the write strobe is low, and output enable stays inactive for the whole write. A standby input parks the memory in its low-power retention state. When standby ends, the block keeps refusing requests for one full cycle time. Parameter checks at elaboration reject a zero clock period and empty widths.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and right after it is released, the memory is deselected (`mem_cs_n`=1, `mem_cs`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `rsp_valid`=0. After release `req_ready` is 1.
- R2: The two chip selects always carry opposite levels. Both are active only during the strobe phase of a read or a write.
- R3: A read holds the selects and `mem_oe_n`=0 with `mem_we_n`=1 for NRD = ceil(max(read cycle, address access, enable access) / clock) cycles. The data bus is sampled on the last edge of that window. `rsp_valid` is high for exactly the following cycle, with the sampled byte on `rsp_rdata`.
- R4: A write holds `mem_oe_n`=1 throughout and `mem_we_n`=0 for NWR = ceil(max(pulse width, data setup, address-to-end) / clock) cycles. `mem_dq_oe` is 1 exactly while `mem_we_n` is 0, so the data is stable for the whole pulse and is released on the edge where the strobe rises.
- R5: Successive access starts are at least one cycle time apart. With a request held waiting, a read is followed by the next accept NRD+NTURN+1 cycles later, and a write by max(NWR, NRC)+1 cycles later, where NRC = ceil(cycle time / clock).
- R6: After `mem_oe_n` rises at the end of a read, `req_ready` stays low for NTURN = max(1, ceil(output-float time / clock)) cycles. `mem_dq_oe` is never 1 within that float time.
- R7: When `sleep_req` is 1 in idle, the block deselects the memory, raises `sleep_ack` and holds `req_ready` at 0. Requests presented during standby are ignored and do not write the memory.
- R8: After `sleep_req` falls, `req_ready` returns NRC+1 cycles after the cycle in which the fall was presented.
- R9: `req_ready` is 0 whenever an access, turnaround, standby or recovery is in progress. `mem_addr` does not change while the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (17) | Byte address |
| req_wdata | input | DW (8) | Write byte |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | DW (8) | Read byte |
| sleep_req | input | 1 | Request for retention standby |
| sleep_ack | output | 1 | Memory is in standby |
| mem_addr | output | AW (17) | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_cs | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | DW (8) | Data driven to the memory |
| mem_dq_in | input | DW (8) | Data returned by the memory |
| mem_dq_oe | output | 1 | Enable for the block's data driver |

## Verification
The hardest case to reach is a write that directly follows a read. It probes whether the data driver turns on while the memory may still be driving the bus. The bench holds a write request valid throughout a read, so the write is accepted on the first possible edge. The bench's memory model timestamps the moment its outputs are released and flags any driver overlap. A second hard case is a request held throughout standby: the bench later reads that address back to show it never reached the array.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_TURN,
      ST_WRITE,
      ST_WGAP,
      ST_SLEEP,
      ST_WAKE
   } sram_st_e;

   // nanoseconds -> whole clock cycles, rounded up
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
      return (ns + per - 1) / per;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
   import sram_ctl_pkg::*;
#(
   parameter int unsigned CW     = 5,
   parameter int unsigned N_RD   = 18,
   parameter int unsigned N_WR   = 13,
   parameter int unsigned N_GAP  = 5,
   parameter int unsigned N_TURN = 8,
   parameter int unsigned N_REC  = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          sleep_req,
   input  logic          tmr_done,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val,
   output logic          req_ready,
   output logic          accept,
   output logic          capture,
   output logic          cs_n,
   output logic          cs,
   output logic          oe_n,
   output logic          we_n,
   output logic          dq_oe,
   output logic          sleep_ack
);

   localparam sram_st_e    WR_EXIT = (N_GAP > 0) ? ST_WGAP : ST_IDLE;
   localparam int unsigned GAP_LD  = (N_GAP > 0) ? N_GAP - 1 : 0;

   sram_st_e st_q, st_d;

   assign req_ready = (st_q == ST_IDLE) && !sleep_req;
   assign accept    = req_ready && req_valid;

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (sleep_req) begin
               st_d = ST_SLEEP;
            end else if (req_valid) begin
               st_d     = req_write ? ST_WRITE : ST_READ;
               tmr_load = 1'b1;
               tmr_val  = req_write ? CW'(N_WR - 1) : CW'(N_RD - 1);
            end
         end
         ST_READ: begin
            if (tmr_done) begin
               capture  = 1'b1;
               st_d     = ST_TURN;
               tmr_load = 1'b1;
               tmr_val  = CW'(N_TURN - 1);
            end
         end
         ST_TURN:  if (tmr_done) st_d = ST_IDLE;
         ST_WRITE: begin
            if (tmr_done) begin
               st_d     = WR_EXIT;
               tmr_load = 1'b1;
               tmr_val  = CW'(GAP_LD);
            end
         end
         ST_WGAP:  if (tmr_done) st_d = ST_IDLE;
         ST_SLEEP: begin
            if (!sleep_req) begin
               st_d     = ST_WAKE;
               tmr_load = 1'b1;
               tmr_val  = CW'(N_REC - 1);
            end
         end
         ST_WAKE:  if (tmr_done) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   // strobes are registered from the next state so the pins never glitch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cs_n      <= 1'b1;
         cs        <= 1'b0;
         oe_n      <= 1'b1;
         we_n      <= 1'b1;
         dq_oe     <= 1'b0;
         sleep_ack <= 1'b0;
      end else begin
         st_q      <= st_d;
         cs_n      <= !((st_d == ST_READ) || (st_d == ST_WRITE));
         cs        <= (st_d == ST_READ) || (st_d == ST_WRITE);
         oe_n      <= (st_d != ST_READ);
         we_n      <= (st_d != ST_WRITE);
         dq_oe     <= (st_d == ST_WRITE);
         sleep_ack <= (st_d == ST_SLEEP);
      end
   end

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n || sleep_ack) |-> !req_ready); // R9
   AST_SLEEP_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_ack |-> (cs_n && !cs)); // R7

endmodule

// File: rtl/sram_ctl_datapath.sv
`timescale 1ns/1ps
module sram_ctl_datapath #(
   parameter int unsigned AW = 17,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          capture,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [DW-1:0] dq_in,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] dq_out,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr      <= '0;
         dq_out    <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         if (accept) begin
            addr   <= req_addr;
            dq_out <= req_wdata;
         end
         rsp_valid <= capture;
         if (capture) rsp_rdata <= dq_in;
      end
   end

   AST_RSP_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R3

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int unsigned AW        = 17,
   parameter int unsigned DW        = 8,
   parameter int unsigned CLK_NS    = 4,
   parameter int unsigned T_RC_NS   = 70,
   parameter int unsigned T_AA_NS   = 70,
   parameter int unsigned T_OE_NS   = 35,
   parameter int unsigned T_WP_NS   = 50,
   parameter int unsigned T_AW_NS   = 50,
   parameter int unsigned T_DW_NS   = 30,
   parameter int unsigned T_HZ_NS   = 30,
   parameter int unsigned T_REC_NS  = 70
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   input  logic          sleep_req,
   output logic          sleep_ack,
   output logic [AW-1:0] mem_addr,
   output logic          mem_cs_n,
   output logic          mem_cs,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [DW-1:0] mem_dq_out,
   input  logic [DW-1:0] mem_dq_in,
   output logic          mem_dq_oe
);

   localparam int unsigned CLK_P  = (CLK_NS == 0) ? 1 : CLK_NS;
   localparam int unsigned N_RC   = umax(1, ns_to_cyc(T_RC_NS, CLK_P));
   localparam int unsigned N_RD   = umax(N_RC, umax(ns_to_cyc(T_AA_NS, CLK_P),
                                                    ns_to_cyc(T_OE_NS, CLK_P)));
   localparam int unsigned N_WR   = umax(1, umax(ns_to_cyc(T_WP_NS, CLK_P),
                                         umax(ns_to_cyc(T_AW_NS, CLK_P),
                                              ns_to_cyc(T_DW_NS, CLK_P))));
   localparam int unsigned N_GAP  = (N_RC > N_WR) ? N_RC - N_WR : 0;
   localparam int unsigned N_TURN = umax(1, ns_to_cyc(T_HZ_NS, CLK_P));
   localparam int unsigned N_REC  = umax(1, ns_to_cyc(T_REC_NS, CLK_P));
   localparam int unsigned N_MAX  = umax(umax(N_RD, N_WR), umax(N_REC, umax(N_TURN, N_GAP)));
   localparam int unsigned CW     = $clog2(N_MAX + 1);

   generate
      if (CLK_NS == 0) begin : g_bad_clk
         $error("sram_ctl: CLK_NS must be non-zero");
      end
      if (AW == 0 || DW == 0) begin : g_bad_width
         $error("sram_ctl: AW and DW must be non-zero");
      end
   endgenerate

   logic          tmr_load, tmr_done, accept, capture;
   logic [CW-1:0] tmr_val;

   sram_ctl_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   sram_ctl_fsm #(
      .CW     (CW),
      .N_RD   (N_RD),
      .N_WR   (N_WR),
      .N_GAP  (N_GAP),
      .N_TURN (N_TURN),
      .N_REC  (N_REC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .sleep_req (sleep_req),
      .tmr_done  (tmr_done),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .req_ready (req_ready),
      .accept    (accept),
      .capture   (capture),
      .cs_n      (mem_cs_n),
      .cs        (mem_cs),
      .oe_n      (mem_oe_n),
      .we_n      (mem_we_n),
      .dq_oe     (mem_dq_oe),
      .sleep_ack (sleep_ack)
   );

   sram_ctl_datapath #(.AW(AW), .DW(DW)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .dq_in     (mem_dq_in),
      .addr      (mem_addr),
      .dq_out    (mem_dq_out),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   AST_CS_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs == !mem_cs_n); // R2
   AST_WRITE_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n); // R4
   AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n && !mem_cs_n)); // R4
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R9
   AST_NO_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> !mem_dq_oe); // R6

endmodule

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;

   localparam int TCK    = 4;
   localparam int C_RC   = (70 + TCK - 1) / TCK;
   localparam int C_RD   = C_RC;
   localparam int C_WR   = (50 + TCK - 1) / TCK;
   localparam int C_TURN = (30 + TCK - 1) / TCK;
   localparam int SP_R   = C_RD + C_TURN + 1;
   localparam int SP_W   = ((C_WR > C_RC) ? C_WR : C_RC) + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, sleep_req = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_valid, sleep_ack;
   logic [7:0]  rsp_rdata;
   logic [16:0] mem_addr;
   logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = 8'hEE;

   always #2 clk = ~clk;

   sram_ctl dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sleep_req(sleep_req), .sleep_ack(sleep_ack),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
   );

   int n_tests = 0, n_fail = 0, cyc = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] seed(input logic [16:0] a);
      return a[7:0] ^ {a[16:13], a[12:9]} ^ 8'h5A;
   endfunction

   logic [7:0] chip    [int];
   logic [7:0] ref_mem [int];

   function automatic logic [7:0] chip_rd(input logic [16:0] a);
      return chip.exists(int'(a)) ? chip[int'(a)] : seed(a);
   endfunction
   function automatic logic [7:0] ref_rd(input logic [16:0] a);
      return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : seed(a);
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // ---------------- behavioural memory model ----------------
   bit          p_sel, p_rd, p_wr, p_dqoe, have_start;
   logic [16:0] p_addr;
   logic [7:0]  p_dq;
   longint      rd_t0, wp_t0, dq_t0, rel_t = -1000, last_start;

   always @(negedge clk) begin
      bit sel, rd, wr;
      longint et;
      if (!rst_n) begin
         p_sel = 0; p_rd = 0; p_wr = 0; p_dqoe = 0; have_start = 0;
         mem_dq_in <= 8'hEE;
      end else begin
         et  = longint'($time) - 2;
         sel = !mem_cs_n && mem_cs;
         rd  = sel && !mem_oe_n && mem_we_n;
         wr  = sel && !mem_we_n;
         chk(mem_cs == !mem_cs_n, "R2", "select pair", mem_cs, !mem_cs_n);
         if (sel && !p_sel) begin
            if (have_start) chk(et - last_start >= 70, "R5", "start to start ns", et - last_start, 70);
            last_start = et; have_start = 1;
         end
         if (sel && p_sel && mem_addr != p_addr)
            chk(0, "R9", "address moved while selected", mem_addr, p_addr);
         if (wr && !p_wr) wp_t0 = et;
         if (wr) chk(mem_oe_n, "R4", "oe_n during write", mem_oe_n, 1);
         if (p_wr && !wr) begin
            chk(et - wp_t0 >= 50, "R4", "write pulse ns", et - wp_t0, 50);
            chk(p_dqoe && (et - dq_t0 >= 30), "R4", "data setup ns", et - dq_t0, 30);
            chk(!mem_dq_oe, "R4", "driver released with strobe", mem_dq_oe, 0);
            chip[int'(p_addr)] = p_dq;
         end
         if (mem_dq_oe && (!p_dqoe || mem_dq_out != p_dq)) dq_t0 = et;
         if (p_rd && !rd) rel_t = et;
         if (mem_dq_oe) chk(!rd && (et - rel_t >= 30), "R6", "bus contention gap ns", et - rel_t, 30);
         if (rd && (!p_rd || mem_addr != p_addr)) rd_t0 = et;
         mem_dq_in <= (rd && (longint'($time) + 2 - rd_t0 >= 70)) ? chip_rd(mem_addr) : 8'hEE;
         p_sel = sel; p_rd = rd; p_wr = wr; p_dqoe = mem_dq_oe;
         p_addr = mem_addr; p_dq = mem_dq_out;
      end
   end

   // ---------------- response reference ----------------
   int         due_q[$];
   logic [7:0] dat_q[$];

   always @(negedge clk) begin
      bit due;
      if (rst_n) begin
         due = (due_q.size() > 0) && (due_q[0] == cyc);
         if (due || rsp_valid) begin
            chk(rsp_valid == due, "R3", "response pulse cycle", rsp_valid, due);
            if (due) begin
               chk(rsp_rdata == dat_q[0], "R3", "read data", rsp_rdata, dat_q[0]);
               void'(due_q.pop_front());
               void'(dat_q.pop_front());
            end
         end
      end
   end

   // ---------------- driver ----------------
   int last_acc = 0;
   bit last_w = 0, have_acc = 0;

   task automatic issue(input bit w, input logic [16:0] a, input logic [7:0] d, input bit b2b);
      int acc;
      req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      acc = cyc + 1;
      if (b2b && have_acc)
         chk(acc - last_acc == (last_w ? SP_W : SP_R), "R5,R9", "accept spacing",
             acc - last_acc, last_w ? SP_W : SP_R);
      if (w) ref_mem[int'(a)] = d;
      else begin
         due_q.push_back(acc + C_RD);
         dat_q.push_back(ref_rd(a));
      end
      last_acc = acc; last_w = w; have_acc = 1;
      @(negedge clk);
      req_valid = 0;
   endtask

   initial begin
      #(TCK * 200000);
      if (!finished) begin
         chk(0, "WDOG", "watchdog expired", cyc, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(mem_cs_n && !mem_cs, "R1", "deselected in reset", {mem_cs_n, mem_cs}, 2);
      chk(mem_oe_n && mem_we_n, "R1", "strobes idle in reset", {mem_oe_n, mem_we_n}, 3);
      chk(!mem_dq_oe && !rsp_valid, "R1", "no drive/response in reset", {mem_dq_oe, rsp_valid}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready, "R1", "ready after reset", req_ready, 1);
      chk(mem_cs_n && !mem_cs, "R1", "deselected after reset", {mem_cs_n, mem_cs}, 2);

      issue(1, 17'h00001, 8'h3C, 0);
      issue(1, 17'h1FFFF, 8'hA5, 1);
      issue(0, 17'h00001, 8'h00, 1);
      issue(0, 17'h1FFFF, 8'h00, 1);
      issue(0, 17'h00100, 8'h00, 1);
      issue(1, 17'h00001, 8'hC3, 1);   // write held behind a read: turnaround
      issue(0, 17'h00001, 8'h00, 1);

      // R6: ready stays low through the float window after a read
      issue(0, 17'h00002, 8'h00, 0);
      while (!mem_oe_n) @(negedge clk);
      n = 0;
      while (!req_ready && n < 100) begin @(negedge clk); n++; end
      chk(n == C_TURN, "R6", "turnaround cycles", n, C_TURN);

      for (int i = 0; i < 16; i++)
         issue(1, 17'((i * 7919 + 3) & 17'h1FFFF), 8'((i * 37 + 5) & 8'hFF), i != 0);
      for (int i = 0; i < 16; i++)
         issue(0, 17'((i * 7919 + 3) & 17'h1FFFF), 8'h00, 1);

      // R7 / R8: standby and recovery
      while (!req_ready) @(negedge clk);
      sleep_req = 1;
      @(negedge clk);
      chk(sleep_ack, "R7", "standby acknowledged", sleep_ack, 1);
      chk(mem_cs_n && !mem_cs, "R7", "deselected in standby", {mem_cs_n, mem_cs}, 2);
      req_valid = 1; req_write = 1; req_addr = 17'h00ABC; req_wdata = 8'h99;
      for (int i = 0; i < 6; i++) begin
         chk(!req_ready, "R7", "ready low in standby", req_ready, 0);
         @(negedge clk);
      end
      req_valid = 0;
      sleep_req = 0;
      n = 0;
      while (!req_ready && n < 100) begin @(negedge clk); n++; end
      chk(n == C_RC + 1, "R8", "recovery lockout cycles", n, C_RC + 1);
      chk(!sleep_ack, "R8", "standby left", sleep_ack, 0);

      issue(0, 17'h00ABC, 8'h00, 0);   // R7: held write must not have landed
      issue(0, 17'h1FFFF, 8'h00, 1);   // retained contents

      repeat (40) @(negedge clk);
      chk(due_q.size() == 0, "R3", "all responses returned", due_q.size(), 0);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule